// File: doc/BRIEF.md
# Host Register Window with Reflection Word

This block is the register slave behind the host port of a peripheral FPGA. It has a fixed bank of ten 16-bit words. They cover identification (board straps, design version, two capability words), a pending-interrupt word with its mask, a status word, and two control words. The host reaches them over a plain synchronous bus. The bus has a request strobe, a write flag and a word address. A read returns its data one cycle after the request.

The first word is a loopback check. Whatever the host writes there reads back with every bit inverted. A bus that floats or is shorted to a constant cannot produce that pattern, so one write and one read prove the register path works. Identification words come from parameters or strap inputs, and host writes do not change them. Pending interrupts are latched from input pulses and cleared when the host writes ones. A single interrupt line is raised while any pending bit is also enabled.

Top module: `host_reg_window`

## Requirements
- R1: The word addresses are fixed: 0 reflection, 1 board straps, 2 design version, 3 capability, 4 extended capability, 5 interrupt pending, 6 interrupt enable, 7 status, 8 control, 9 extended control. Every word is 16 bits.
- R2: A write to word 0 makes it read back as the bitwise inverse of the written value (0xDEAD reads 0x2152).
- R3: After reset, word 0 reads 0xFFFF.
- R4: Word 2 reads MAJOR*100+MINOR from the version parameters.
- R5: Word 1 carries the hardware revision strap in bits 3:0, the video-channel strap in bit 12 and the console-side strap in bit 13. All other bits are zero.
- R6: Words 3 and 4 read the capability parameters and word 7 reads the status input. Writes to words 1, 2, 3, 4 and 7 change nothing.
- R7: A read (req_i=1, we_i=0) drives rvalid_o and rdata_o in the following cycle. rvalid_o stays low after writes and idle cycles, and rdata_o holds its last value.
- R8: Reads of addresses 10 and above return zero.
- R9: A pulse on irq_pulse_i bit k sets pending bit k. Writing 1 to bit k of word 5 clears it. A pulse and a clear in the same cycle leave the bit set.
- R10: irq_o is high exactly when some bit is set in both word 5 and word 6.
- R11: Words 6, 8 and 9 are read/write and reset to zero. Words 8 and 9 drive ctrl_o and ext_ctrl_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_pulse_i | input | NIRQ | Interrupt set pulses |
| video_chan_i | input | 1 | Video-channel design strap |
| console_side_i | input | 1 | Console-side design strap |
| hw_rev_i | input | 4 | Hardware revision strap |
| status_i | input | 16 | Live status word |
| irq_o | output | 1 | Enabled-interrupt indication |
| ctrl_o | output | 16 | Control word |
| ext_ctrl_o | output | 16 | Extended control word |

## Verification
The bench sets the version to 3.04, which checks that a minor number below ten gives 304 and not 34. It uses capability words with mixed bit patterns (0xA5C3, 0x0F81), so a swapped or stuck word shows up. With NIRQ at the full 16 and AW at 4, every bit of the pending word is reachable. The six addresses from 10 to 15 test the zero return for unused addresses.

// File: rtl/hrw_pkg.sv
package hrw_pkg;
  localparam int REG_W    = 16;
  localparam int NUM_REGS = 10;
  localparam int A_REFL   = 0;
  localparam int A_BOARD  = 1;
  localparam int A_DVER   = 2;
  localparam int A_CAP    = 3;
  localparam int A_XCAP   = 4;
  localparam int A_PEND   = 5;
  localparam int A_IEN    = 6;
  localparam int A_STAT   = 7;
  localparam int A_CTRL   = 8;
  localparam int A_XCTRL  = 9;
  localparam int BIT_VIDEO   = 12;
  localparam int BIT_CONSOLE = 13;
  localparam int REV_W       = 4;
endpackage

// File: rtl/hrw_reflect.sv
module hrw_reflect #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rd_val_o
);
  logic [W-1:0] stored_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   stored_q <= '0;
    else if (wr_i) stored_q <= wdata_i;
  end

  // inverted on the way out: a stuck or floating bus cannot echo this
  assign rd_val_o = ~stored_q;

  a_r2_inverse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (rd_val_o == ~$past(wdata_i)));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(rd_val_o));
endmodule

// File: rtl/hrw_rw_reg.sv
module hrw_rw_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= wdata_i;
  end

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o));
endmodule

// File: rtl/hrw_irq_bank.sv
module hrw_irq_bank #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pulse_i,
  input  logic         clr_wr_i,
  input  logic         en_wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  logic [N-1:0] clr_mask;

  assign clr_mask = clr_wr_i ? wdata_i : '0;

  // a pulse in the clearing cycle wins: the event is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o & ~clr_mask) | pulse_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_o <= '0;
    else if (en_wr_i) en_o <= wdata_i;
  end

  assign irq_o = |(pend_o & en_o);

  a_r9_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pulse_i) |=> ((pend_o & $past(pulse_i)) == $past(pulse_i)));
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr_i |=> ((pend_o & $past(wdata_i & ~pulse_i)) == '0));
  a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o == '0) |-> !irq_o);
endmodule

// File: rtl/host_reg_window.sv
module host_reg_window
  import hrw_pkg::*;
#(
  parameter int          AW            = 4,
  parameter int          NIRQ          = 16,
  parameter int          DESIGN_MAJOR  = 1,
  parameter int          DESIGN_MINOR  = 0,
  parameter logic [15:0] CAP_WORD      = 16'h0000,
  parameter logic [15:0] XCAP_WORD     = 16'h0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [15:0]     wdata_i,
  output logic [15:0]     rdata_o,
  output logic            rvalid_o,
  input  logic [NIRQ-1:0] irq_pulse_i,
  input  logic            video_chan_i,
  input  logic            console_side_i,
  input  logic [3:0]      hw_rev_i,
  input  logic [15:0]     status_i,
  output logic            irq_o,
  output logic [15:0]     ctrl_o,
  output logic [15:0]     ext_ctrl_o
);
  localparam int          IDX_W    = $clog2(NUM_REGS);
  localparam logic [15:0] DVER_VAL = 16'(DESIGN_MAJOR * 100 + DESIGN_MINOR);

  logic [NUM_REGS-1:0] sel, wr_sel;
  logic                wr, rd;
  logic [REG_W-1:0]    words [NUM_REGS];
  logic [REG_W-1:0]    refl_val, board_word, rd_mux;
  logic [NIRQ-1:0]     pend, ien;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign sel[i]    = (addr_i == AW'(i));
    assign wr_sel[i] = wr & sel[i];
  end

  hrw_reflect #(.W(REG_W)) i_refl (
    .clk_i, .rst_ni,
    .wr_i    (wr_sel[A_REFL]),
    .wdata_i (wdata_i),
    .rd_val_o(refl_val)
  );

  hrw_irq_bank #(.N(NIRQ)) i_irq (
    .clk_i, .rst_ni,
    .pulse_i (irq_pulse_i),
    .clr_wr_i(wr_sel[A_PEND]),
    .en_wr_i (wr_sel[A_IEN]),
    .wdata_i (wdata_i[NIRQ-1:0]),
    .pend_o  (pend),
    .en_o    (ien),
    .irq_o   (irq_o)
  );

  hrw_rw_reg #(.W(REG_W)) i_ctrl (
    .clk_i, .rst_ni, .wr_i(wr_sel[A_CTRL]), .wdata_i(wdata_i), .q_o(ctrl_o)
  );

  hrw_rw_reg #(.W(REG_W)) i_xctrl (
    .clk_i, .rst_ni, .wr_i(wr_sel[A_XCTRL]), .wdata_i(wdata_i), .q_o(ext_ctrl_o)
  );

  always_comb begin
    board_word                 = '0;
    board_word[REV_W-1:0]      = hw_rev_i;
    board_word[BIT_VIDEO]      = video_chan_i;
    board_word[BIT_CONSOLE]    = console_side_i;
  end

  assign words[A_REFL]  = refl_val;
  assign words[A_BOARD] = board_word;
  assign words[A_DVER]  = DVER_VAL;
  assign words[A_CAP]   = CAP_WORD;
  assign words[A_XCAP]  = XCAP_WORD;
  assign words[A_PEND]  = REG_W'(pend);
  assign words[A_IEN]   = REG_W'(ien);
  assign words[A_STAT]  = status_i;
  assign words[A_CTRL]  = ctrl_o;
  assign words[A_XCTRL] = ext_ctrl_o;

  assign rd_mux = (addr_i < AW'(NUM_REGS)) ? words[addr_i[IDX_W-1:0]] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_mux;
    end
  end

  a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  a_r7_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> (!rvalid_o && $stable(rdata_o)));
  a_r8_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (addr_i >= AW'(NUM_REGS))) |=> (rdata_o == '0));
endmodule

// File: tb/test_host_reg_window.sv
`timescale 1ns/1ps
module test_host_reg_window;
  localparam int          MAJ  = 3;
  localparam int          MIN  = 4;
  localparam logic [15:0] CAP  = 16'hA5C3;
  localparam logic [15:0] XCAP = 16'h0F81;

  logic        clk = 0, rst_ni = 0;
  logic        req = 0, we = 0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0, pulse = '0, status = '0;
  logic        vid = 0, con = 0;
  logic [3:0]  rev = '0;
  logic [15:0] rdata, ctrl, xctrl;
  logic        rvalid, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_refl, m_pend, m_en, m_ctrl, m_xctrl, m_rdata;
  logic        m_rvalid;

  always #10 clk = ~clk;

  host_reg_window #(.AW(4), .NIRQ(16), .DESIGN_MAJOR(MAJ), .DESIGN_MINOR(MIN),
                    .CAP_WORD(CAP), .XCAP_WORD(XCAP)) i_host_reg_window (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .irq_pulse_i(pulse),
    .video_chan_i(vid), .console_side_i(con), .hw_rev_i(rev), .status_i(status),
    .irq_o(irq), .ctrl_o(ctrl), .ext_ctrl_o(xctrl)
  );

  function automatic logic [15:0] model_read(input logic [3:0] a);
    case (a)
      4'd0: return ~m_refl;
      4'd1: return {2'b00, con, vid, 8'h00, rev};
      4'd2: return 16'(MAJ * 100 + MIN);
      4'd3: return CAP;
      4'd4: return XCAP;
      4'd5: return m_pend;
      4'd6: return m_en;
      4'd7: return status;
      4'd8: return m_ctrl;
      4'd9: return m_xctrl;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic rq, input logic w, input logic [3:0] a,
                      input logic [15:0] d, input logic [15:0] p, input string tag);
    @(negedge clk);
    req = rq; we = w; addr = a; wdata = d; pulse = p;
    @(posedge clk);
    m_rvalid = rq && !w;
    if (m_rvalid) m_rdata = model_read(a);
    if (rq && w) begin
      case (a)
        4'd0: m_refl  = d;
        4'd5: m_pend  = m_pend & ~d;
        4'd6: m_en    = d;
        4'd8: m_ctrl  = d;
        4'd9: m_xctrl = d;
        default: ;
      endcase
    end
    m_pend = m_pend | p;
    #1;
    chk("R7", "rvalid", 16'(rvalid), 16'(m_rvalid));
    chk(tag, "rdata", rdata, m_rdata);
    chk("R10", "irq", 16'(irq), 16'(|(m_pend & m_en)));
    chk("R11", "ctrl", ctrl, m_ctrl);
    chk("R11", "ext_ctrl", xctrl, m_xctrl);
    @(negedge clk);
    req = 0; we = 0; pulse = '0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    step(1, 0, a, 16'h0, 16'h0, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input string tag);
    step(1, 1, a, d, 16'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    m_refl = '0; m_pend = '0; m_en = '0; m_ctrl = '0; m_xctrl = '0;
    m_rdata = '0; m_rvalid = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "reset ctrl", ctrl, 16'h0);
    chk("R7", "reset rvalid", 16'(rvalid), 16'h0);
    @(negedge clk); rst_ni = 1;

    rd(0, "R3");                       // 0xFFFF after reset
    for (int a = 0; a < 10; a++) rd(4'(a), "R1");

    wr(0, 16'hDEAD, "R2"); rd(0, "R2");
    wr(0, 16'h0000, "R2"); rd(0, "R2");
    wr(0, 16'h5A5A, "R2"); rd(0, "R2");

    rd(2, "R4");

    vid = 1; con = 0; rev = 4'h9; rd(1, "R5");
    vid = 0; con = 1; rev = 4'hF; rd(1, "R5");
    vid = 1; con = 1; rev = 4'h0; rd(1, "R5");

    status = 16'h1234; rd(7, "R6");
    wr(1, 16'hFFFF, "R6"); wr(2, 16'hFFFF, "R6"); wr(3, 16'h0000, "R6");
    wr(4, 16'hFFFF, "R6"); wr(7, 16'h0000, "R6");
    rd(1, "R6"); rd(2, "R6"); rd(3, "R6"); rd(4, "R6"); rd(7, "R6");
    status = 16'hBEEF; rd(7, "R6");

    step(0, 0, 0, 16'h0, 16'h0, "R7");  // idle: rvalid low, rdata held
    for (int a = 10; a < 16; a++) rd(4'(a), "R8");

    step(0, 0, 0, 16'h0, 16'h8011, "R9"); rd(5, "R9");
    wr(5, 16'h0010, "R9"); rd(5, "R9");
    step(1, 1, 5, 16'h8001, 16'h0001, "R9"); rd(5, "R9");  // set wins bit 0
    wr(6, 16'h0002, "R10");              // enable a bit not pending
    step(0, 0, 0, 16'h0, 16'h0002, "R10");
    wr(5, 16'h0002, "R10");
    wr(6, 16'h0001, "R10"); rd(6, "R11");
    wr(5, 16'hFFFF, "R9"); rd(5, "R9");

    wr(8, 16'hC0DE, "R11"); wr(9, 16'h7E57, "R11");
    rd(8, "R11"); rd(9, "R11");
    wr(8, 16'h0000, "R11"); rd(8, "R11");

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule